// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This block watches the internal bus of a processor and raises a break request when a programmed condition is met. It has two channels, A and B. Each channel compares the observed address against a reference address under a per-bit mask. It also requires a chosen cycle kind: instruction fetch, data read or data write. Channel B can also compare the data value against its own reference and mask. A hit on either channel sets that channel's match flag. The flag stays set until software clears it.

When channel A is set to watch fetches, it can break before or after execution. In break-before mode the request follows the fetch hit at once. In break-after mode the hit is held, and the request is raised at the next instruction-retire strobe. Software can also turn on PC tracing. The PC of the cycle that produced a hit is then captured into a readable register.

Bus observation is passive, so it has no ready signal. The unit never applies back-pressure, and each cycle with `bus_valid` high is evaluated exactly once. The register port is a plain single-cycle write strobe with combinational read data.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every control field, both match flags and the trace register read 0, and `brk_req` is 0.
- R2: A channel's flag sets in the cycle after a bus cycle that satisfies its condition. The flags are bit 0 (A) and bit 1 (B) of the control register at index 0. A set flag stays 1 while no write reaches the control register.
- R3: A write to the control register clears a flag only where the written bit is 0. A written 1 leaves the flag unchanged. If a clearing write coincides with a hit on that channel, the flag ends up 1.
- R4: The address condition holds when `(bus_addr ^ ref) & ~mask` is zero. Reference and mask are at indices 1 and 2 for A, and at 3 and 4 for B.
- R5: A hit on channel B, or on channel A with control bit 3 at 0, drives `brk_req` high in the following cycle.
- R6: With control bit 3 at 1 and channel A watching fetches, an A hit is held. `brk_req` goes high in the cycle after the next `insn_retire`, and only once per held hit.
- R7: With control bit 6 at 1, channel B also requires `(bus_data ^ dref) & ~dmask` to be zero, with dref at index 5 and dmask at index 6. With bit 6 at 0, the data value is ignored.
- R8: Control bits 5:4 always read 0, whatever value is written to them.
- R9: `brk_req` is a one-cycle pulse per triggering cycle. Simultaneous hits on both channels give a single pulse, and cycles without a trigger leave it low.
- R10: With control bit 2 at 1, a hit on either channel copies `bus_pc` into the trace register at index 7. With bit 2 at 0, the trace register holds its value.
- R11: The channel kind fields are bits 9:8 (A) and 11:10 (B), encoded as 00 off, 01 fetch, 10 data read and 11 data write. A bus cycle of a different kind never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Observed bus cycle present |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = data write, 0 = read |
| bus_addr | input | 32 | Observed address |
| bus_data | input | 32 | Observed data value |
| bus_pc | input | 32 | PC of the instruction owning the cycle |
| insn_retire | input | 1 | Instruction retire strobe |
| brk_req | output | 1 | Break request pulse |

## Verification
Assertions check these rules on every cycle:
- Match flags stay set without a control write, and every hit sets its flag.
- An immediate hit is followed by a request, and a held hit is released on retire.
- A deferred hit raises no early request, and `brk_req` stays low with no trigger.
- The trace register holds while tracing is off.

Only the bench scenarios show the rest. These are the address and data mask arithmetic, and the write-one-has-no-effect and match-beats-clear rules on the flags. They also include the reserved bits reading zero and the exact PC captured.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    KIND_OFF    = 2'b00,
    KIND_FETCH  = 2'b01,
    KIND_DREAD  = 2'b10,
    KIND_DWRITE = 2'b11
  } bus_kind_e;

  localparam int NCH  = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int RAW  = 3;
  typedef logic [RAW-1:0] reg_idx_t;

  // register indices
  localparam reg_idx_t RG_CTRL  = 3'd0;
  localparam reg_idx_t RG_AREF0 = 3'd1;  // channel g: ref at 1+2g, mask at 2+2g
  localparam reg_idx_t RG_DREF  = 3'd5;
  localparam reg_idx_t RG_DMSK  = 3'd6;
  localparam reg_idx_t RG_TRACE = 3'd7;

  // control bit positions; flag of channel g sits at bit g
  localparam int CB_TRACE  = 2;
  localparam int CB_AFTER  = 3;
  localparam int CB_BDATA  = 6;
  localparam int CB_KIND_A = 8;
  localparam int CB_KIND_B = 10;
endpackage

// File: rtl/bkpt_chan_match.sv
module bkpt_chan_match
  import bkpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         bus_valid,
  input  logic         bus_fetch,
  input  logic         bus_write,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  bus_kind_e    kind,
  input  logic         data_en,
  input  logic [W-1:0] addr_ref,
  input  logic [W-1:0] addr_msk,
  input  logic [W-1:0] data_ref,
  input  logic [W-1:0] data_msk,
  output logic         hit
);
  logic kind_ok, addr_ok, data_ok;

  always_comb begin
    case (kind)
      KIND_FETCH:  kind_ok = bus_fetch;
      KIND_DREAD:  kind_ok = !bus_fetch && !bus_write;
      KIND_DWRITE: kind_ok = !bus_fetch && bus_write;
      default:     kind_ok = 1'b0;
    endcase
  end

  assign addr_ok = (((bus_addr ^ addr_ref) & ~addr_msk) == '0);
  assign data_ok = !data_en || (((bus_data ^ data_ref) & ~data_msk) == '0);
  assign hit     = bus_valid && kind_ok && addr_ok && data_ok;
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  reg_idx_t       reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic [NCH-1:0] hit,
  input  logic [W-1:0]   bus_pc,
  output logic           trace_en,
  output logic           a_after,
  output logic           b_data_en,
  output bus_kind_e      kind     [NCH],
  output logic [W-1:0]   addr_ref [NCH],
  output logic [W-1:0]   addr_msk [NCH],
  output logic [W-1:0]   data_ref,
  output logic [W-1:0]   data_msk
);
  logic [NCH-1:0] flag_q;
  logic [W-1:0]   trace_pc_q;
  logic           ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == RG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_en   <= 1'b0;
      a_after    <= 1'b0;
      b_data_en  <= 1'b0;
      kind[CH_A] <= KIND_OFF;
      kind[CH_B] <= KIND_OFF;
      data_ref   <= '0;
      data_msk   <= '0;
      trace_pc_q <= '0;
    end else begin
      if (ctrl_wr) begin
        trace_en   <= reg_wdata[CB_TRACE];
        a_after    <= reg_wdata[CB_AFTER];
        b_data_en  <= reg_wdata[CB_BDATA];
        kind[CH_A] <= bus_kind_e'(reg_wdata[CB_KIND_A +: 2]);
        kind[CH_B] <= bus_kind_e'(reg_wdata[CB_KIND_B +: 2]);
      end
      if (reg_we && reg_addr == RG_DREF) data_ref <= reg_wdata;
      if (reg_we && reg_addr == RG_DMSK) data_msk <= reg_wdata;
      if (trace_en && |hit) trace_pc_q <= bus_pc;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam reg_idx_t IDX_REF = reg_idx_t'(RG_AREF0 + 2 * g);
    localparam reg_idx_t IDX_MSK = reg_idx_t'(RG_AREF0 + 2 * g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g]   <= 1'b0;
        addr_ref[g] <= '0;
        addr_msk[g] <= '0;
      end else begin
        // a hit outranks a software clear; a written 1 is ignored
        if (hit[g])                        flag_q[g] <= 1'b1;
        else if (ctrl_wr && !reg_wdata[g]) flag_q[g] <= 1'b0;
        if (reg_we && reg_addr == IDX_REF) addr_ref[g] <= reg_wdata;
        if (reg_we && reg_addr == IDX_MSK) addr_msk[g] <= reg_wdata;
      end
    end

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[g] && !ctrl_wr |=> flag_q[g]);
    p_hit_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag_q[g]);
  end

  p_trace_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> $stable(trace_pc_q));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RG_CTRL: begin
        reg_rdata[NCH-1:0]          = flag_q;
        reg_rdata[CB_TRACE]         = trace_en;
        reg_rdata[CB_AFTER]         = a_after;
        reg_rdata[CB_BDATA]         = b_data_en;
        reg_rdata[CB_KIND_A +: 2]   = kind[CH_A];
        reg_rdata[CB_KIND_B +: 2]   = kind[CH_B];
      end
      3'd1:     reg_rdata = addr_ref[CH_A];
      3'd2:     reg_rdata = addr_msk[CH_A];
      3'd3:     reg_rdata = addr_ref[CH_B];
      3'd4:     reg_rdata = addr_msk[CH_B];
      RG_DREF:  reg_rdata = data_ref;
      RG_DMSK:  reg_rdata = data_msk;
      default:  reg_rdata = trace_pc_q;
    endcase
  end
endmodule

// File: rtl/bkpt_req_gen.sv
module bkpt_req_gen
  import bkpt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           a_defer,
  input  logic           insn_retire,
  output logic           brk_req
);
  logic pend_q, release_now, fire_now;

  assign release_now = pend_q && insn_retire;
  assign fire_now    = (hit[CH_A] && !a_defer) || hit[CH_B] || release_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      pend_q  <= (pend_q && !insn_retire) || (hit[CH_A] && a_defer);
      brk_req <= fire_now;
    end
  end

  p_before_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[CH_A] && !a_defer |=> brk_req);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && insn_retire |=> brk_req);
  p_defer_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[CH_A] && a_defer && !hit[CH_B] && !(pend_q && insn_retire) |=> !brk_req);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) && !(pend_q && insn_retire) |=> !brk_req);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic           bus_valid,
  input  logic           bus_fetch,
  input  logic           bus_write,
  input  logic [W-1:0]   bus_addr,
  input  logic [W-1:0]   bus_data,
  input  logic [W-1:0]   bus_pc,
  input  logic           insn_retire,
  output logic           brk_req
);
  logic           trace_en, a_after, b_data_en;
  bus_kind_e      kind     [NCH];
  logic [W-1:0]   addr_ref [NCH];
  logic [W-1:0]   addr_msk [NCH];
  logic [W-1:0]   data_ref, data_msk;
  logic [NCH-1:0] hit;
  logic           a_defer;

  bkpt_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit), .bus_pc(bus_pc),
    .trace_en(trace_en), .a_after(a_after), .b_data_en(b_data_en),
    .kind(kind), .addr_ref(addr_ref), .addr_msk(addr_msk),
    .data_ref(data_ref), .data_msk(data_msk)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_match
    // only channel B carries a data condition
    localparam bit HAS_DATA = (g == CH_B);
    bkpt_chan_match #(.W(W)) match_i (
      .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_data(bus_data), .kind(kind[g]),
      .data_en(HAS_DATA ? b_data_en : 1'b0),
      .addr_ref(addr_ref[g]), .addr_msk(addr_msk[g]),
      .data_ref(HAS_DATA ? data_ref : '0),
      .data_msk(HAS_DATA ? data_msk : '0),
      .hit(hit[g])
    );
  end

  assign a_defer = a_after && (kind[CH_A] == KIND_FETCH);

  bkpt_req_gen req_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .a_defer(a_defer),
    .insn_retire(insn_retire), .brk_req(brk_req)
  );
endmodule

// File: tb/bkpt_unit_tb.sv
`timescale 1ns/1ps
module bkpt_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0, bus_pc = '0;
  logic        insn_retire = 1'b0;
  logic        brk_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int cyc; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bkpt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_pc(bus_pc), .insn_retire(insn_retire),
    .brk_req(brk_req)
  );

  // kind codes: 0 off, 1 fetch, 2 data read, 3 data write
  function automatic logic [31:0] ctrl(bit fa, bit fb, bit tr, bit aft, bit bd,
                                       logic [1:0] ka, logic [1:0] kb);
    logic [31:0] v = '0;
    v[0] = fa; v[1] = fb; v[2] = tr; v[3] = aft; v[6] = bd;
    v[9:8] = ka; v[11:10] = kb;
    return v;
  endfunction

  // monitor: compares each request pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit exp = (q.size() > 0) && (q[0].cyc == cyc);
      if (exp || brk_req) begin
        n_chk++;
        if (brk_req !== exp) begin
          n_fail++;
          $display("FAIL %s brk_req at cycle %0d: actual %b expected %b",
                   exp ? q[0].tag : "R9", cyc, brk_req, exp);
        end
        if (exp) void'(q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    reg_addr = a; #1;
    n_chk++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic bus(input bit f, input bit w, input logic [31:0] a,
                     input logic [31:0] d, input logic [31:0] pc,
                     input bit exp, input string tag);
    bus_valid = 1'b1; bus_fetch = f; bus_write = w;
    bus_addr = a; bus_data = d; bus_pc = pc;
    @(posedge clk); #1;
    if (exp) q.push_back('{cyc, tag});
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic retire(input bit exp, input string tag);
    insn_retire = 1'b1;
    @(posedge clk); #1;
    if (exp) q.push_back('{cyc, tag});
    insn_retire = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_rd(3'd0, 32'h0, "R1");
    chk_rd(3'd7, 32'h0, "R1");
    n_chk++;
    if (brk_req !== 1'b0) begin
      n_fail++; $display("FAIL R1 brk_req: actual %b expected 0", brk_req);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R5 / R2: channel A fetch break, before mode
    wr(3'd1, 32'h1000); wr(3'd2, 32'h0);
    wr(3'd0, ctrl(0,0,0,0,0,2'd1,2'd0));
    bus(1,0,32'h1000,0,32'h1000,1,"R5");
    chk_rd(3'd0, ctrl(1,0,0,0,0,2'd1,2'd0), "R2");
    bus(1,0,32'h1004,0,32'h1004,0,"R4");
    chk_rd(3'd0, ctrl(1,0,0,0,0,2'd1,2'd0), "R2");

    // R3: write 1 keeps, write 0 clears
    wr(3'd0, ctrl(1,1,0,0,0,2'd1,2'd0));
    chk_rd(3'd0, ctrl(1,0,0,0,0,2'd1,2'd0), "R3");
    wr(3'd0, ctrl(0,0,0,0,0,2'd1,2'd0));
    chk_rd(3'd0, ctrl(0,0,0,0,0,2'd1,2'd0), "R3");

    // R4 address mask, R11 kind mismatch
    wr(3'd2, 32'h0000_00F0);
    bus(1,0,32'h10F0,0,0,1,"R4");
    bus(1,0,32'h1100,0,0,0,"R4");
    bus(0,0,32'h1000,0,0,0,"R11");
    wr(3'd0, ctrl(0,0,0,0,0,2'd1,2'd0));
    chk_rd(3'd0, ctrl(0,0,0,0,0,2'd1,2'd0), "R11");

    // R6 break after execution
    wr(3'd0, ctrl(0,0,0,1,0,2'd1,2'd0));
    bus(1,0,32'h1000,0,0,0,"R6");
    repeat (2) @(negedge clk);
    retire(1,"R6");
    retire(0,"R6");

    // R7 channel B data condition
    wr(3'd3, 32'h2000); wr(3'd4, 32'h0);
    wr(3'd5, 32'hAB);   wr(3'd6, 32'h0);
    wr(3'd0, ctrl(0,0,0,0,1,2'd0,2'd3));
    bus(0,1,32'h2000,32'hAB,0,1,"R7");
    bus(0,1,32'h2000,32'hAC,0,0,"R7");
    bus(0,0,32'h2000,32'hAB,0,0,"R11");
    wr(3'd0, ctrl(0,0,0,0,0,2'd0,2'd3));
    bus(0,1,32'h2000,32'hAC,0,1,"R7");

    // R9 both channels in one cycle give one pulse
    wr(3'd1, 32'h3000); wr(3'd2, 32'h0); wr(3'd3, 32'h3000);
    wr(3'd0, ctrl(0,0,0,0,0,2'd2,2'd2));
    bus(0,0,32'h3000,0,0,1,"R9");
    chk_rd(3'd0, ctrl(1,1,0,0,0,2'd2,2'd2), "R2");

    // R10 trace capture on and off
    wr(3'd0, ctrl(0,0,1,0,0,2'd2,2'd0));
    bus(0,0,32'h3000,0,32'h1234,1,"R10");
    chk_rd(3'd7, 32'h1234, "R10");
    wr(3'd0, ctrl(0,0,0,0,0,2'd2,2'd0));
    bus(0,0,32'h3000,0,32'h5555,1,"R10");
    chk_rd(3'd7, 32'h1234, "R10");

    // R3 hit wins over a coinciding clear
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = ctrl(0,0,0,0,0,2'd2,2'd0);
    bus_valid = 1'b1; bus_fetch = 1'b0; bus_write = 1'b0; bus_addr = 32'h3000;
    @(posedge clk); #1;
    q.push_back('{cyc, "R3"});
    reg_we = 1'b0; bus_valid = 1'b0;
    @(negedge clk);
    chk_rd(3'd0, ctrl(1,0,0,0,0,2'd2,2'd0), "R3");

    // R8 reserved bits, R11 channel off
    wr(3'd0, ctrl(0,0,0,0,0,2'd0,2'd0) | 32'h30);
    chk_rd(3'd0, 32'h0, "R8");
    bus(0,0,32'h3000,0,0,0,"R11");
    repeat (3) @(negedge clk);

    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 pending pulses: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule